// File: doc/BRIEF.md
# Fetch and Memory Stall Sequencer

This block sequences the front end of a scalar processor that retires at most one instruction per cycle and stops while a cache miss is outstanding. While it runs, it asks for one 32-bit instruction word every cycle at the current program counter. If the instruction cache reports a miss, nothing retires and the sequencer waits for a completion pulse. The word that the miss returned is then executed in the following cycle without a second fetch. If an executed instruction touches memory and the data cache misses, the instruction still retires, and the sequencer then waits for the completion before it fetches again.

The block keeps the PC and next-PC pair. A fault on the current instruction raises a trap strobe in place of the PC update. The block also keeps four free-running counters: retired instructions, memory references, cycles stalled on instruction misses and cycles stalled on data misses. An enable input moves the sequencer between running and idle. A completion pulse that arrives in a state with no outstanding miss is flagged on an error strobe.

Top module: `fetch_stall_seq`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `state` is RUN (code 0), `pc` equals `reset_vec`, `npc` equals `reset_vec`+4, and all four counters are zero.
- R2: In RUN with `run_en` high, `fetch_req` is 1, `fetch_addr` is `pc` with bits 1:0 forced to zero and `fetch_phys` equals `pc` bit 0. In every other case `fetch_req` is 0.
- R3: In RUN with `run_en` high, no fault and `icache_hit` low, `exec_valid` is 0, the PC is unchanged and `state` becomes IMISS (code 2) on the next cycle.
- R4: In IMISS, `done_pulse` moves `state` to IHELD (code 3). In DMISS (code 4), `done_pulse` moves it to RUN. Without the pulse, both states hold.
- R5: In IHELD, `fetch_req` is 0 and the held instruction executes: without a fault, `exec_valid` is 1 and `state` then returns to RUN, or goes to DMISS under the R6 condition.
- R6: When an instruction executes with `mem_ref` high and `dcache_hit` low, it still retires and advances the PC, and `state` becomes DMISS on the next cycle.
- R7: On each cycle with `exec_valid` high, `pc` takes the old `npc` and `npc` advances by 4 on the next cycle. Otherwise both hold.
- R8: When the sequencer is active (RUN with `run_en` high, or IHELD) and `fault` is high, `trap` is 1, `exec_valid` is 0, the PC and counters hold, and `state` becomes RUN.
- R9: `inst_cnt` increments once for each cycle with `exec_valid` high. `mref_cnt` increments when such a cycle also has `mem_ref` high.
- R10: `istall_cnt` increments on every cycle spent in IMISS and `dstall_cnt` on every cycle spent in DMISS, including the cycle in which the completion arrives.
- R11: `done_pulse` in RUN, IDLE (code 1) or IHELD raises `comp_err` in that cycle and has no effect on the state transition.
- R12: In RUN with `run_en` low, nothing is fetched or executed and `state` becomes IDLE. In IDLE, `run_en` high returns `state` to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reset_vec | input | AW | PC value loaded at reset |
| run_en | input | 1 | Run enable; low parks the sequencer in IDLE |
| icache_hit | input | 1 | Instruction cache hit for this cycle's fetch |
| dcache_hit | input | 1 | Data cache hit for the executing instruction |
| mem_ref | input | 1 | Executing instruction accesses memory |
| fault | input | 1 | Current instruction faults |
| done_pulse | input | 1 | Miss completion pulse |
| fetch_req | output | 1 | Fetch request this cycle |
| fetch_addr | output | AW | Word-aligned fetch address |
| fetch_phys | output | 1 | Fetch bypasses address translation |
| exec_valid | output | 1 | An instruction retires this cycle |
| trap | output | 1 | Fault trap strobe |
| comp_err | output | 1 | Completion pulse arrived with no outstanding miss |
| state | output | 3 | Sequencer state code |
| pc | output | AW | Program counter |
| npc | output | AW | Next program counter |
| inst_cnt | output | CW | Retired instruction count |
| mref_cnt | output | CW | Memory reference count |
| istall_cnt | output | CW | Instruction miss stall cycles |
| dstall_cnt | output | CW | Data miss stall cycles |

## Verification
The assertions check the following on every cycle: the completion transitions out of both stall states, that IHELD never fetches, that a trap leaves the PC in place, that a retired instruction moves the PC to the old next-PC and bumps the retire counter, and that a fetch miss retires nothing. The bench's reference model covers what only sequences show. That includes the accumulated stall-cycle totals, data misses in a held instruction, idle entry and exit, and stray completions in non-stall states. It also covers the physical-access flag from an odd reset vector.

// File: rtl/fss_pkg.sv
package fss_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_IMISS = 3'd2,
        ST_IHELD = 3'd3,
        ST_DMISS = 3'd4
    } seq_state_e;

    localparam int NUM_CNT = 4;
    localparam int CNT_INST = 0;
    localparam int CNT_MREF = 1;
    localparam int CNT_ISTALL = 2;
    localparam int CNT_DSTALL = 3;
endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
    import fss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       icache_hit,
    input  logic       dcache_hit,
    input  logic       mem_ref,
    input  logic       fault,
    input  logic       done_pulse,
    output seq_state_e st_q,
    output logic       fetch_req,
    output logic       exec_fire,
    output logic       trap,
    output logic       comp_err,
    output logic [NUM_CNT-1:0] cnt_inc
);
    typedef struct packed {
        seq_state_e st;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  active;
    logic  dmiss;

    always_comb begin
        r_d       = r_q;
        active    = (r_q.st == ST_RUN && run_en) || (r_q.st == ST_IHELD);
        fetch_req = (r_q.st == ST_RUN) && run_en;
        trap      = active && fault;
        exec_fire = active && !fault && ((r_q.st == ST_IHELD) || icache_hit);
        dmiss     = exec_fire && mem_ref && !dcache_hit;
        comp_err  = done_pulse && (r_q.st != ST_IMISS) && (r_q.st != ST_DMISS);

        case (r_q.st)
            ST_RUN: begin
                if (!run_en)          r_d.st = ST_IDLE;
                else if (fault)       r_d.st = ST_RUN;
                else if (!icache_hit) r_d.st = ST_IMISS;
                else if (dmiss)       r_d.st = ST_DMISS;
                else                  r_d.st = ST_RUN;
            end
            ST_IDLE:  r_d.st = run_en ? ST_RUN : ST_IDLE;
            ST_IMISS: r_d.st = done_pulse ? ST_IHELD : ST_IMISS;
            ST_IHELD: r_d.st = dmiss ? ST_DMISS : ST_RUN;
            ST_DMISS: r_d.st = done_pulse ? ST_RUN : ST_DMISS;
            default:  r_d.st = ST_RUN;
        endcase

        cnt_inc             = '0;
        cnt_inc[CNT_INST]   = exec_fire;
        cnt_inc[CNT_MREF]   = exec_fire && mem_ref;
        cnt_inc[CNT_ISTALL] = (r_q.st == ST_IMISS);
        cnt_inc[CNT_DSTALL] = (r_q.st == ST_DMISS);
    end

    always_ff @(posedge clk) begin
        if (rst) r_q.st <= ST_RUN;
        else     r_q    <= r_d;
    end

    assign st_q = r_q.st;
endmodule

// File: rtl/fss_pc_unit.sv
module fss_pc_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reset_vec,
    input  logic          advance,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] npc
);
    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] npc;
    } pc_t;

    pc_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (advance) begin
            p_d.pc  = p_q.npc;
            p_d.npc = p_q.npc + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q.pc  <= reset_vec;
            p_q.npc <= reset_vec + STEP;
        end else begin
            p_q <= p_d;
        end
    end

    assign pc  = p_q.pc;
    assign npc = p_q.npc;
endmodule

// File: rtl/fss_counters.sv
module fss_counters
    import fss_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] inc,
    output logic [CW-1:0]      cnt [NUM_CNT]
);
    localparam logic [CW-1:0] ONE = CW'(1);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic [CW-1:0] c_d, c_q;

        always_comb begin
            c_d = c_q;
            if (inc[i]) c_d = c_q + ONE;
        end

        always_ff @(posedge clk) begin
            if (rst) c_q <= '0;
            else     c_q <= c_d;
        end

        assign cnt[i] = c_q;
    end
endmodule

// File: rtl/fetch_stall_seq.sv
module fetch_stall_seq
    import fss_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reset_vec,
    input  logic          run_en,
    input  logic          icache_hit,
    input  logic          dcache_hit,
    input  logic          mem_ref,
    input  logic          fault,
    input  logic          done_pulse,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_phys,
    output logic          exec_valid,
    output logic          trap,
    output logic          comp_err,
    output logic [2:0]    state,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] npc,
    output logic [CW-1:0] inst_cnt,
    output logic [CW-1:0] mref_cnt,
    output logic [CW-1:0] istall_cnt,
    output logic [CW-1:0] dstall_cnt
);
    localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

    seq_state_e         st;
    logic [NUM_CNT-1:0] inc;
    logic [CW-1:0]      cnt [NUM_CNT];

    fss_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .icache_hit (icache_hit),
        .dcache_hit (dcache_hit),
        .mem_ref    (mem_ref),
        .fault      (fault),
        .done_pulse (done_pulse),
        .st_q       (st),
        .fetch_req  (fetch_req),
        .exec_fire  (exec_valid),
        .trap       (trap),
        .comp_err   (comp_err),
        .cnt_inc    (inc)
    );

    fss_pc_unit #(.AW(AW)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .reset_vec (reset_vec),
        .advance   (exec_valid),
        .pc        (pc),
        .npc       (npc)
    );

    fss_counters #(.CW(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (inc),
        .cnt (cnt)
    );

    assign state      = st;
    assign fetch_addr = pc & WORD_MASK;
    assign fetch_phys = pc[0];
    assign inst_cnt   = cnt[CNT_INST];
    assign mref_cnt   = cnt[CNT_MREF];
    assign istall_cnt = cnt[CNT_ISTALL];
    assign dstall_cnt = cnt[CNT_DSTALL];
endmodule

// File: rtl/fss_chk.sv
module fss_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          icache_hit,
    input logic          fault,
    input logic          done_pulse,
    input logic          fetch_req,
    input logic          exec_valid,
    input logic          trap,
    input logic [2:0]    state,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] npc,
    input logic [CW-1:0] inst_cnt
);
    // R4
    imiss_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd2 && done_pulse) |=> state == 3'd3);

    // R4
    dmiss_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd4 && done_pulse) |=> state == 3'd0);

    // R5
    held_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd3) |-> !fetch_req);

    // R3
    imiss_noexec_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !icache_hit && !fault) |-> !exec_valid);

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        exec_valid |=> pc == $past(npc));

    // R8
    trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        trap |=> $stable(pc));

    // R9
    inst_count_chk: assert property (@(posedge clk) disable iff (rst)
        exec_valid |=> inst_cnt == $past(inst_cnt) + CW'(1));
endmodule

bind fetch_stall_seq fss_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .icache_hit (icache_hit),
    .fault      (fault),
    .done_pulse (done_pulse),
    .fetch_req  (fetch_req),
    .exec_valid (exec_valid),
    .trap       (trap),
    .state      (state),
    .pc         (pc),
    .npc        (npc),
    .inst_cnt   (inst_cnt)
);

// File: tb/fetch_stall_seq_tb_top.sv
module fetch_stall_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam logic [2:0] S_RUN = 3'd0, S_IDLE = 3'd1, S_IMISS = 3'd2,
                           S_IHELD = 3'd3, S_DMISS = 3'd4;

    logic clk = 1'b0;
    logic rst, run_en, icache_hit, dcache_hit, mem_ref, fault, done_pulse;
    logic [AW-1:0] reset_vec;
    logic fetch_req, fetch_phys, exec_valid, trap, comp_err;
    logic [AW-1:0] fetch_addr, pc, npc;
    logic [2:0] state;
    logic [CW-1:0] inst_cnt, mref_cnt, istall_cnt, dstall_cnt;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [2:0]    m_st;
    logic [AW-1:0] m_pc, m_npc;
    logic [CW-1:0] m_cnt [4];
    string         m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_stall_seq #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .reset_vec(reset_vec), .run_en(run_en),
        .icache_hit(icache_hit), .dcache_hit(dcache_hit), .mem_ref(mem_ref),
        .fault(fault), .done_pulse(done_pulse), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_phys(fetch_phys), .exec_valid(exec_valid),
        .trap(trap), .comp_err(comp_err), .state(state), .pc(pc), .npc(npc),
        .inst_cnt(inst_cnt), .mref_cnt(mref_cnt), .istall_cnt(istall_cnt),
        .dstall_cnt(dstall_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic e_active();
        return (m_st == S_RUN && run_en) || (m_st == S_IHELD);
    endfunction

    function automatic logic e_exec();
        return e_active() && !fault && ((m_st == S_IHELD) || icache_hit);
    endfunction

    task automatic model_reset(input logic [AW-1:0] v);
        m_st = S_RUN; m_pc = v; m_npc = v + 4;
        for (int i = 0; i < 4; i++) m_cnt[i] = '0;
        m_tag = "R1";
    endtask

    task automatic check_outputs();
        logic ex;
        ex = e_exec();
        chk(m_tag, {29'd0, state}, {29'd0, m_st});
        chk(m_st == S_IDLE ? "R12" : "R2", {31'd0, fetch_req}, {31'd0, (m_st == S_RUN) && run_en});
        chk("R2", fetch_addr, m_pc & ~32'd3);
        chk("R2", {31'd0, fetch_phys}, {31'd0, m_pc[0]});
        chk(m_st == S_IHELD ? "R5" : "R3", {31'd0, exec_valid}, {31'd0, ex});
        chk("R8", {31'd0, trap}, {31'd0, e_active() && fault});
        chk("R11", {31'd0, comp_err}, {31'd0, done_pulse && m_st != S_IMISS && m_st != S_DMISS});
        chk("R7", pc, m_pc);
        chk("R7", npc, m_npc);
        chk("R9", 32'(inst_cnt), 32'(m_cnt[0]));
        chk("R9", 32'(mref_cnt), 32'(m_cnt[1]));
        chk("R10", 32'(istall_cnt), 32'(m_cnt[2]));
        chk("R10", 32'(dstall_cnt), 32'(m_cnt[3]));
    endtask

    task automatic model_step();
        logic ex, dm;
        ex = e_exec();
        dm = ex && mem_ref && !dcache_hit;
        if (m_st == S_IMISS) m_cnt[2] = m_cnt[2] + 1;
        if (m_st == S_DMISS) m_cnt[3] = m_cnt[3] + 1;
        if (ex) begin
            m_cnt[0] = m_cnt[0] + 1;
            if (mem_ref) m_cnt[1] = m_cnt[1] + 1;
            m_pc = m_npc; m_npc = m_npc + 4;
        end
        m_tag = done_pulse ? "R11" : "R4";
        case (m_st)
            S_RUN: begin
                if (!run_en)          begin m_st = S_IDLE;  m_tag = "R12"; end
                else if (fault)       begin m_st = S_RUN;   m_tag = "R8";  end
                else if (!icache_hit) begin m_st = S_IMISS; m_tag = "R3";  end
                else if (dm)          begin m_st = S_DMISS; m_tag = "R6";  end
                else                  m_st = S_RUN;
            end
            S_IDLE:  begin m_st = run_en ? S_RUN : S_IDLE; m_tag = "R12"; end
            S_IMISS: begin m_st = done_pulse ? S_IHELD : S_IMISS; m_tag = "R4"; end
            S_IHELD: begin m_st = dm ? S_DMISS : S_RUN; m_tag = "R5"; end
            default: begin m_st = done_pulse ? S_RUN : S_DMISS; m_tag = "R4"; end
        endcase
    endtask

    task automatic drive(input logic r, input logic ih, input logic dh,
                         input logic mr, input logic f, input logic d);
        run_en = r; icache_hit = ih; dcache_hit = dh;
        mem_ref = mr; fault = f; done_pulse = d;
    endtask

    task automatic cycle();
        #1;
        check_outputs();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [AW-1:0] v);
        reset_vec = v;
        drive(1, 1, 1, 0, 0, 0);
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset(v);
    endtask

    task automatic rand_cycle();
        logic d;
        if (m_st == S_IMISS || m_st == S_DMISS) d = ($urandom % 100) < 30;
        else d = ($urandom % 100) < 3;
        drive(($urandom % 100) < 95, ($urandom % 100) < 75, ($urandom % 100) < 70,
              ($urandom % 100) < 40, ($urandom % 100) < 8, d);
        cycle();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        @(negedge clk);
        // R1: reset with an odd vector, which marks the fetch physical (R2)
        do_reset(32'h0000_1001);
        cycle();
        // R3 then R4 then R5: instruction miss, 3 stall cycles, held execute
        drive(1, 0, 1, 0, 0, 0); cycle();
        drive(1, 1, 1, 0, 0, 0); cycle();
        cycle();
        drive(1, 1, 1, 0, 0, 1); cycle();
        drive(1, 0, 1, 0, 0, 0); cycle();
        // R6: data miss on a retiring instruction, then completion
        drive(1, 1, 0, 1, 0, 0); cycle();
        drive(1, 1, 1, 0, 0, 0); cycle();
        drive(1, 1, 1, 0, 0, 1); cycle();
        // R8: fault
        drive(1, 1, 1, 0, 1, 0); cycle();
        // R11: stray completion in RUN
        drive(1, 1, 1, 0, 0, 1); cycle();
        // R12: idle entry and exit
        drive(0, 1, 1, 0, 0, 0); cycle();
        cycle();
        drive(1, 1, 1, 0, 0, 1); cycle();
        drive(1, 1, 1, 0, 0, 0); cycle();
        for (int i = 0; i < 2500; i++) rand_cycle();
        // R1: second reset with an aligned vector
        do_reset(32'h0000_2000);
        cycle();
        for (int i = 0; i < 2500; i++) rand_cycle();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule